// File: doc/BRIEF.md
# Banked TLB special-register port

This block keeps a small software-managed translation cache behind a set of special registers. Software selects a register bank with a 2-bit bank number. Banks 1 and 2 each own a separate store of entries. Banks 0 and 3 are plain register files. Inside a translation bank, four registers matter. A selector (register 4) names the set and the entry. A high mirror (register 6) and a low mirror (register 5) stage the entry's two words. A cause register (register 7) receives every high-mirror write.

An entry is committed only when software writes the low mirror. The new low word comes from the write data and the new high word from the cause register. If the entry being replaced was valid, the block pulses an invalidate output that carries the evicted virtual page. A read of any register while a translation bank is selected first reloads both mirrors from the selected entry. A separate PID-change input requests a flush of the current PID's entries when the 8-bit PID actually changes.

Top module: `tlb_sreg_port`

## Requirements
- R1: After reset, every register and entry is zero (all entries invalid), and `rdata_o`, `inval_o`, `inval_page_o`, `flush_o` and `flush_pid_o` are zero.
- R2: In banks 0 and 3, a write stores only the addressed register. It never raises `inval_o` and never changes register 7. A later read returns the stored value.
- R3: In banks 1 and 2, a write to register 6 stores the value in register 6 and in register 7.
- R4: In banks 1 and 2, a write to register 5 commits the entry at set = selector bits [5:4] and index = selector bits [3:0]. The entry's low word is the write data and its high word is the current register 7.
- R5: When an R4 commit overwrites an entry whose low word bit 3 is 1, `inval_o` is 1 for exactly the next cycle. `inval_page_o` then equals the old high word with bits [12:0] cleared (8 KiB pages). If bit 3 was 0, no pulse appears.
- R6: A read in bank 1 or 2 loads register 6 and register 5 with the selected entry's high and low words before it returns data. A read of register 6 or 5 therefore returns the entry's words.
- R7: Banks 1 and 2 have separate entry stores. A commit in one bank is not visible in the other bank.
- R8: On `pid_flush_i`, if `pid_new_i` differs from `pid_cur_i`, `flush_o` pulses for the next cycle with `flush_pid_o` = `pid_cur_i`. If the two are equal, there is no pulse.
- R9: `rdata_o` is registered: it shows the result of a read one cycle after the read and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_i | input | 2 | Selected register bank |
| we_i | input | 1 | Special-register write strobe |
| waddr_i | input | 4 | Write register number |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Special-register read strobe |
| raddr_i | input | 4 | Read register number |
| rdata_o | output | 32 | Registered read data |
| pid_flush_i | input | 1 | PID change request |
| pid_new_i | input | 8 | Incoming PID |
| pid_cur_i | input | 8 | Current PID |
| inval_o | output | 1 | Page invalidate pulse |
| inval_page_o | output | 32 | Evicted virtual page address |
| flush_o | output | 1 | PID flush pulse |
| flush_pid_o | output | 8 | PID whose entries are to be flushed |

## Verification
Every visible result is due exactly one clock after the edge that samples its stimulus. Read data, the invalidate pulse with its page, and the flush pulse with its PID all follow this rule. Storage effects (mirror copies, committed entries, separate banks) show up only through a later read, which adds its own cycle.

The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and the outputs are compared 2 ns after every rising edge. Directed checks sample in the half cycle after the operation's edge, before the next rising edge can clear a pulse.

// File: rtl/tlb_sreg_pkg.sv
package tlb_sreg_pkg;
  localparam int DW         = 32;
  localparam int PAGE_SHIFT = 13;
  localparam int VALID_BIT  = 3;
  localparam logic [3:0] SR_SEL   = 4'd4;
  localparam logic [3:0] SR_LO    = 4'd5;
  localparam logic [3:0] SR_HI    = 4'd6;
  localparam logic [3:0] SR_CAUSE = 4'd7;

  typedef struct packed {
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_sreg_bank.sv
module tlb_sreg_bank
  import tlb_sreg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_REGS  = 16,
  parameter int SEL_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              cause_we_i,
  input  logic              mir_we_i,
  input  logic [DW-1:0]     mir_hi_i,
  input  logic [DW-1:0]     mir_lo_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DW-1:0]     cause_o
);
  logic [DW-1:0] regs_q [NUM_BANKS][NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int r = 0; r < NUM_REGS; r++)
          regs_q[b][r] <= '0;
    end else begin
      if (mir_we_i) begin
        regs_q[bank_i][ADDR_W'(SR_HI)] <= mir_hi_i;
        regs_q[bank_i][ADDR_W'(SR_LO)] <= mir_lo_i;
      end
      // explicit writes win over a same-cycle mirror reload
      if (we_i) begin
        regs_q[bank_i][waddr_i] <= wdata_i;
        if (cause_we_i) regs_q[bank_i][ADDR_W'(SR_CAUSE)] <= wdata_i;
      end
    end
  end

  logic [DW-1:0] sel_full;
  assign sel_full = regs_q[bank_i][ADDR_W'(SR_SEL)];
  assign sel_o    = sel_full[SEL_W-1:0];
  assign cause_o  = regs_q[bank_i][ADDR_W'(SR_CAUSE)];
  assign rdata_o  = regs_q[bank_i][raddr_i];

  a_r3_cause_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && cause_we_i) |=> (!$stable(bank_i) || cause_o == $past(wdata_i)));
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_sreg_pkg::*;
#(
  parameter int NUM_TLB_BANKS = 2,
  parameter int NUM_SETS      = 4,
  parameter int SET_ENTRIES   = 16,
  localparam int TB_W   = $clog2(NUM_TLB_BANKS),
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int IDX_W  = $clog2(SET_ENTRIES),
  localparam int DEPTH  = NUM_TLB_BANKS * NUM_SETS * SET_ENTRIES,
  localparam int ADDR_W = TB_W + SET_W + IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [TB_W-1:0]  tb_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [IDX_W-1:0] idx_i,
  input  tlb_entry_t       wentry_i,
  output tlb_entry_t       rentry_o
);
  tlb_entry_t mem_q [DEPTH];
  logic [ADDR_W-1:0] addr;
  assign addr = {tb_i, set_i, idx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr] <= wentry_i;
    end
  end

  assign rentry_o = mem_q[addr];

  a_r4_commit_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i ##1 $stable(addr)) |-> rentry_o == $past(wentry_i));
endmodule

// File: rtl/tlb_pid_flush.sv
module tlb_pid_flush #(
  parameter int PID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [PID_W-1:0] pid_new_i,
  input  logic [PID_W-1:0] pid_cur_i,
  output logic             flush_o,
  output logic [PID_W-1:0] flush_pid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_o     <= 1'b0;
      flush_pid_o <= '0;
    end else begin
      flush_o <= req_i && (pid_new_i != pid_cur_i);
      if (req_i) flush_pid_o <= pid_cur_i;
    end
  end

  a_r8_same_pid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && pid_new_i == pid_cur_i) |=> !flush_o);
  a_r8_flush_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(req_i));
endmodule

// File: rtl/tlb_sreg_port.sv
module tlb_sreg_port
  import tlb_sreg_pkg::*;
#(
  parameter int NUM_SETS    = 4,
  parameter int SET_ENTRIES = 16,
  parameter int PID_W       = 8,
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int IDX_W      = $clog2(SET_ENTRIES),
  localparam int SEL_W      = SET_W + IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       bank_i,
  input  logic             we_i,
  input  logic [3:0]       waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             re_i,
  input  logic [3:0]       raddr_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             pid_flush_i,
  input  logic [PID_W-1:0] pid_new_i,
  input  logic [PID_W-1:0] pid_cur_i,
  output logic             inval_o,
  output logic [DW-1:0]    inval_page_o,
  output logic             flush_o,
  output logic [PID_W-1:0] flush_pid_o
);
  logic             tlb_bank;
  logic [0:0]       tb;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    cause, reg_rdata;
  logic             hi_wr, lo_wr, mir_load;
  tlb_entry_t       cur_entry, new_entry;

  assign tlb_bank = (bank_i == 2'd1) || (bank_i == 2'd2);
  assign tb       = bank_i[1];
  assign hi_wr    = we_i && tlb_bank && (waddr_i == SR_HI);
  assign lo_wr    = we_i && tlb_bank && (waddr_i == SR_LO);
  assign mir_load = re_i && tlb_bank;

  tlb_sreg_bank #(.NUM_BANKS(4), .NUM_REGS(16), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .bank_i, .we_i, .waddr_i, .wdata_i,
    .cause_we_i(hi_wr), .mir_we_i(mir_load),
    .mir_hi_i(cur_entry.hi), .mir_lo_i(cur_entry.lo),
    .raddr_i, .rdata_o(reg_rdata), .sel_o(sel), .cause_o(cause)
  );

  assign new_entry.hi = cause;
  assign new_entry.lo = wdata_i;

  tlb_entry_store #(.NUM_TLB_BANKS(2), .NUM_SETS(NUM_SETS), .SET_ENTRIES(SET_ENTRIES)) u_store (
    .clk_i, .rst_ni, .we_i(lo_wr), .tb_i(tb),
    .set_i(sel[SEL_W-1:IDX_W]), .idx_i(sel[IDX_W-1:0]),
    .wentry_i(new_entry), .rentry_o(cur_entry)
  );

  tlb_pid_flush #(.PID_W(PID_W)) u_pid (
    .clk_i, .rst_ni, .req_i(pid_flush_i), .pid_new_i, .pid_cur_i,
    .flush_o, .flush_pid_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inval_o      <= 1'b0;
      inval_page_o <= '0;
      rdata_o      <= '0;
    end else begin
      inval_o <= lo_wr && cur_entry.lo[VALID_BIT];
      if (lo_wr && cur_entry.lo[VALID_BIT])
        inval_page_o <= {cur_entry.hi[DW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      if (re_i) begin
        if (mir_load && raddr_i == SR_HI)      rdata_o <= cur_entry.hi;
        else if (mir_load && raddr_i == SR_LO) rdata_o <= cur_entry.lo;
        else                                   rdata_o <= reg_rdata;
      end
    end
  end

  a_r5_inval_from_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |-> $past(we_i && tlb_bank && waddr_i == SR_LO));
  a_r2_plain_bank_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !tlb_bank) |=> !inval_o);
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_tlb_sreg_port.sv
module tb_tlb_sreg_port;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  bank = '0;
  logic        we = 1'b0, re = 1'b0, pf = 1'b0;
  logic [3:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  pnew = '0, pcur = '0;
  logic [31:0] rdata, ipage;
  logic        inval, flush;
  logic [7:0]  fpid;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_sreg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .bank_i(bank), .we_i(we), .waddr_i(waddr),
    .wdata_i(wdata), .re_i(re), .raddr_i(raddr), .rdata_o(rdata),
    .pid_flush_i(pf), .pid_new_i(pnew), .pid_cur_i(pcur),
    .inval_o(inval), .inval_page_o(ipage), .flush_o(flush), .flush_pid_o(fpid)
  );

  // behavioural reference
  logic [31:0] m_reg [4][16];
  logic [31:0] m_hi [2][64];
  logic [31:0] m_lo [2][64];
  logic [31:0] e_rdata = '0, e_page = '0;
  logic        e_inval = 1'b0, e_flush = 1'b0;
  logic [7:0]  e_fpid = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) m_reg[b][r] = '0;
      for (int t = 0; t < 2; t++) for (int e = 0; e < 64; e++) begin m_hi[t][e] = '0; m_lo[t][e] = '0; end
      e_rdata = '0; e_page = '0; e_inval = 0; e_flush = 0; e_fpid = '0;
    end else begin
      automatic bit is_tlb = (bank == 1) || (bank == 2);
      automatic int t = (bank == 2) ? 1 : 0;
      automatic int e = m_reg[bank][4] % 64;
      e_inval = 0;
      e_flush = pf && (pnew != pcur);
      if (pf) e_fpid = pcur;
      if (re) begin
        if (is_tlb) begin m_reg[bank][6] = m_hi[t][e]; m_reg[bank][5] = m_lo[t][e]; end
        e_rdata = m_reg[bank][raddr];
      end
      if (we) begin
        if (is_tlb && waddr == 5) begin
          if (m_lo[t][e][3]) begin e_inval = 1; e_page = m_hi[t][e] & 32'hFFFF_E000; end
          m_hi[t][e] = m_reg[bank][7];
          m_lo[t][e] = wdata;
        end
        m_reg[bank][waddr] = wdata;
        if (is_tlb && waddr == 6) m_reg[bank][7] = wdata;
      end
    end
    #2;
    chk(rdata == e_rdata, "R9 rdata vs model", rdata, e_rdata);
    chk(inval == e_inval, "R5 inval vs model", 32'(inval), 32'(e_inval));
    if (e_inval) chk(ipage == e_page, "R5 page vs model", ipage, e_page);
    chk(flush == e_flush, "R8 flush vs model", 32'(flush), 32'(e_flush));
    if (e_flush) chk(fpid == e_fpid, "R8 pid vs model", 32'(fpid), 32'(e_fpid));
  end

  task automatic idle();
    @(negedge clk); we = 0; re = 0; pf = 0;
  endtask
  task automatic wr(input logic [1:0] b, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bank = b; we = 1; waddr = a; wdata = d; re = 0; pf = 0;
    @(negedge clk); we = 0;
  endtask
  task automatic rd(input logic [1:0] b, input logic [3:0] a);
    @(negedge clk); bank = b; re = 1; raddr = a; we = 0; pf = 0;
    @(negedge clk); re = 0;
  endtask
  task automatic pid(input logic [7:0] n, input logic [7:0] c);
    @(negedge clk); pf = 1; pnew = n; pcur = c; we = 0; re = 0;
    @(negedge clk); pf = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rdata == 0 && !inval && !flush && ipage == 0 && fpid == 0, "R1 reset outputs", rdata, 0);
    rd(2'd1, 4'd6);
    chk(rdata == 0, "R1 entry empty after reset", rdata, 0);

    // R3 high write copies into cause
    wr(2'd1, 4'd4, 32'h25);
    wr(2'd1, 4'd6, 32'hABCD_E123);
    rd(2'd1, 4'd7);
    chk(rdata == 32'hABCD_E123, "R3 cause copy", rdata, 32'hABCD_E123);

    // R4 commit into invalid slot: no invalidate
    @(negedge clk); bank = 1; we = 1; waddr = 5; wdata = 32'h0000_0008;
    @(negedge clk); we = 0;
    chk(!inval, "R5 no pulse on invalid victim", 32'(inval), 0);
    wr(2'd1, 4'd6, 32'h0);   // disturb mirror and cause
    rd(2'd1, 4'd6);
    chk(rdata == 32'hABCD_E123, "R4 R6 entry high word reloaded", rdata, 32'hABCD_E123);
    rd(2'd1, 4'd5);
    chk(rdata == 32'h8, "R4 R6 entry low word", rdata, 32'h8);

    // R5 overwrite of a valid entry
    wr(2'd1, 4'd6, 32'h1234_0000);
    @(negedge clk); bank = 1; we = 1; waddr = 5; wdata = 32'h9;
    @(negedge clk); we = 0;
    chk(inval == 1'b1, "R5 pulse on valid victim", 32'(inval), 1);
    chk(ipage == 32'hABCD_E000, "R5 evicted page", ipage, 32'hABCD_E000);
    idle();
    chk(!inval, "R5 pulse lasts one cycle", 32'(inval), 0);

    // R7 bank 2 is separate
    wr(2'd2, 4'd4, 32'h25);
    rd(2'd2, 4'd6);
    chk(rdata == 0, "R7 bank2 does not see bank1 entry", rdata, 0);

    // R6 read of an ordinary register also reloads the mirrors
    wr(2'd1, 4'd6, 32'hDEAD_0000);
    rd(2'd1, 4'd3);
    wr(2'd1, 4'd9, 32'h0);
    rd(2'd1, 4'd3);
    chk(rdata == 0, "R9 plain reg", rdata, 0);

    // boundary selectors
    wr(2'd1, 4'd4, 32'h3F);
    wr(2'd1, 4'd6, 32'hFFFF_FFFF);
    wr(2'd1, 4'd5, 32'h8);
    wr(2'd1, 4'd4, 32'h0);
    rd(2'd1, 4'd6);
    chk(rdata == 0, "R4 set0 idx0 untouched", rdata, 0);
    wr(2'd1, 4'd4, 32'h3F);
    wr(2'd1, 4'd5, 32'h0);
    chk(inval && ipage == 32'hFFFF_E000, "R5 set3 idx15 page", ipage, 32'hFFFF_E000);

    // R2 plain banks
    wr(2'd0, 4'd5, 32'hFFFF_FFFF);
    chk(!inval, "R2 bank0 no invalidate", 32'(inval), 0);
    rd(2'd0, 4'd5);
    chk(rdata == 32'hFFFF_FFFF, "R2 bank0 readback", rdata, 32'hFFFF_FFFF);
    wr(2'd3, 4'd6, 32'h5555_AAAA);
    rd(2'd3, 4'd7);
    chk(rdata == 0, "R2 bank3 cause untouched", rdata, 0);

    // R9 hold
    wr(2'd1, 4'd2, 32'h55);
    rd(2'd1, 4'd2);
    idle(); idle();
    chk(rdata == 32'h55, "R9 rdata holds", rdata, 32'h55);

    // R8 pid flush
    pid(8'h12, 8'h12);
    chk(!flush, "R8 same pid no flush", 32'(flush), 0);
    pid(8'h13, 8'h12);
    chk(flush && fpid == 8'h12, "R8 changed pid flush", 32'(fpid), 32'h12);

    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      automatic int op = $urandom_range(0, 4);
      @(negedge clk);
      bank = 2'($urandom_range(0, 3)); we = 0; re = 0; pf = 0;
      case (op)
        0: begin we = 1; waddr = 4; wdata = $urandom_range(0, 3) * 16 + $urandom_range(0, 2); end
        1: begin we = 1; waddr = 6; wdata = $urandom; end
        2: begin we = 1; waddr = 5; wdata = $urandom; end
        3: begin re = 1; raddr = 4'($urandom_range(0, 15)); end
        default: begin pf = 1; pnew = 8'($urandom_range(0, 3)); pcur = 8'($urandom_range(0, 3)); end
      endcase
    end
    idle(); idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule